// File: doc/BRIEF.md
# Dual-View Integer Register File

This block holds the integer operand state of a processor core: 64 entries of 64 bits, read through two independent combinational read ports and updated through one synchronous write port. The highest entry is a constant zero: it always reads back as zero, and writes aimed at it are dropped.

A single mode input switches all three ports into a narrow 32-bit view. In that view only the lowest sixteen entries can be reached. A read in this view returns the low word of the selected entry with zeros above it. A write in this view stores the 32-bit value sign-extended to the full entry width. Later reads in the wide view therefore see the extended value.

A read that names the entry being written in the same cycle returns the value that the write is about to store. No other forwarding is provided. Reset clears every entry.

Top module: `dual_view_regfile`

## Requirements
- R1: In wide mode (narrow_mode=0), a write with wr_en=1 to an index 0..62 stores all 64 bits of wr_data at the clock edge. Both read ports return that value for that index from the next cycle onward, independently of each other.
- R2: In wide mode, a read of index 63 on either port returns zero.
- R3: A wide-mode write to index 63 changes no entry. Reading all 64 indices afterwards shows the same contents as before the write.
- R4: In narrow mode (narrow_mode=1), the ports use only bits [3:0] of rd_a_idx, rd_b_idx and wr_idx, so an index of 16*k+n names entry n.
- R5: In narrow mode, read data is bits [31:0] of the addressed entry, and bits [63:32] of the output are zero.
- R6: In narrow mode, a write stores {32 copies of wr_data[31], wr_data[31:0]} into the entry, and wr_data[63:32] is ignored. A later wide read of that entry returns the extended value.
- R7: When wr_en=1 and a read port addresses the same effective entry as the write (not entry 63), that port returns the value being stored, formatted for the current view, in the same cycle.
- R8: While rst_n is low, every entry is cleared. After reset every index reads zero in both views.
- R9: With wr_en=0, no entry changes, whatever the values on wr_idx and wr_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all entries |
| narrow_mode | input | 1 | 0 = wide 64-bit view of 64 entries, 1 = narrow 32-bit view of entries 0..15 |
| rd_a_idx | input | 6 | Read port A index |
| rd_a_data | output | 64 | Read port A data, combinational |
| rd_b_idx | input | 6 | Read port B index |
| rd_b_data | output | 64 | Read port B data, combinational |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 6 | Write index |
| wr_data | input | 64 | Write data; in narrow mode only bits [31:0] are used |

## Verification
Each entry gets its own distinct pattern, and walking-one and walking-zero words are also written. These catch address aliasing, stuck data bits and a port that returns the other port's entry. Narrow writes are made with both negative and positive low words and with garbage in the upper half. This separates correct sign extension from zero extension, from a copy of the upper input bits, and from a missing narrow-read mask. Indices with high bits set in narrow mode show whether the upper index bits are folded away. Same-cycle read-write collisions in both views, writes to entry 63, disabled writes and a reset in the middle of the run each test one rule that an otherwise working file could still break.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;

  // View selection shared by every submodule of the register file.
  typedef enum logic {
    VIEW_WIDE   = 1'b0,
    VIEW_NARROW = 1'b1
  } rf_view_e;

endpackage

// File: rtl/rf_index_map.sv
`timescale 1ns/1ps
// Folds a port index onto the entry it names in the current view.
module rf_index_map
  import rf_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NARROW_AW = 4
) (
  input  rf_view_e           view,
  input  logic [ADDR_W-1:0]  idx,
  output logic [ADDR_W-1:0]  eff_idx
);

  generate
    if (NARROW_AW >= ADDR_W) begin : g_no_fold
      // Narrow view covers the whole index space: nothing to fold.
      logic unused_view;
      assign unused_view = view[0];
      assign eff_idx     = idx;
    end else begin : g_fold
      function automatic logic [ADDR_W-1:0] fold_index(
        input rf_view_e          v,
        input logic [ADDR_W-1:0] i
      );
        if (v == VIEW_NARROW)
          return {{(ADDR_W-NARROW_AW){1'b0}}, i[NARROW_AW-1:0]};
        return i;
      endfunction

      assign eff_idx = fold_index(view, idx);
    end
  endgenerate

endmodule

// File: rtl/rf_write_shaper.sv
`timescale 1ns/1ps
// Turns a port write into the value and enable the storage array commits.
module rf_write_shaper
  import rf_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int ADDR_W   = 6,
  parameter int ZERO_IDX = 63
) (
  input  rf_view_e           view,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  eff_idx,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               commit_en,
  output logic [ADDR_W-1:0]  commit_idx,
  output logic [DATA_W-1:0]  commit_data
);

  // Replicates the narrow sign bit across the upper part of the entry.
  function automatic logic [DATA_W-1:0] widen_signed(
    input logic [NARROW_W-1:0] v
  );
    return {{(DATA_W-NARROW_W){v[NARROW_W-1]}}, v};
  endfunction

  function automatic logic is_zero_reg(input logic [ADDR_W-1:0] i);
    return i == ADDR_W'(ZERO_IDX);
  endfunction

  assign commit_en   = wr_en && !is_zero_reg(eff_idx);
  assign commit_idx  = eff_idx;
  assign commit_data = (view == VIEW_NARROW) ? widen_signed(wr_data[NARROW_W-1:0])
                                             : wr_data;

endmodule

// File: rtl/rf_storage.sv
`timescale 1ns/1ps
// Flop array with one write and NUM_RD combinational reads.
module rf_storage #(
  parameter int ENTRIES = 64,
  parameter int DATA_W  = 64,
  parameter int NUM_RD  = 2,
  localparam int ADDR_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit_en,
  input  logic [ADDR_W-1:0]  commit_idx,
  input  logic [DATA_W-1:0]  commit_data,
  input  logic [ADDR_W-1:0]  rd_idx  [NUM_RD],
  output logic [DATA_W-1:0]  rd_raw  [NUM_RD]
);

  logic [DATA_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < ENTRIES; k++) mem[k] <= '0;
    end else if (commit_en) begin
      mem[commit_idx] <= commit_data;
    end
  end

  generate
    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      assign rd_raw[p] = mem[rd_idx[p]];
    end
  endgenerate

endmodule

// File: rtl/rf_read_format.sv
`timescale 1ns/1ps
// Per-port read path: same-cycle bypass, zero register, view formatting.
module rf_read_format
  import rf_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int ADDR_W   = 6,
  parameter int ZERO_IDX = 63
) (
  input  rf_view_e           view,
  input  logic [ADDR_W-1:0]  eff_idx,
  input  logic [DATA_W-1:0]  raw,
  input  logic               commit_en,
  input  logic [ADDR_W-1:0]  commit_idx,
  input  logic [DATA_W-1:0]  commit_data,
  output logic               bypass_hit,
  output logic [DATA_W-1:0]  rd_data
);

  // Low word only, upper bits cleared.
  function automatic logic [DATA_W-1:0] narrow_view(input logic [DATA_W-1:0] v);
    return {{(DATA_W-NARROW_W){1'b0}}, v[NARROW_W-1:0]};
  endfunction

  logic [DATA_W-1:0] selected;
  logic              hits_zero;

  assign bypass_hit = commit_en && (commit_idx == eff_idx);
  assign hits_zero  = (eff_idx == ADDR_W'(ZERO_IDX));

  always_comb begin
    selected = bypass_hit ? commit_data : raw;
    if (hits_zero)
      selected = '0;
    rd_data = (view == VIEW_NARROW) ? narrow_view(selected) : selected;
  end

endmodule

// File: rtl/dual_view_regfile.sv
`timescale 1ns/1ps
// 64x64 register file with a zero entry and a sign-extending 32-bit view.
module dual_view_regfile
  import rf_pkg::*;
#(
  parameter int ENTRIES        = 64,
  parameter int DATA_W         = 64,
  parameter int NARROW_W       = 32,
  parameter int NARROW_ENTRIES = 16,
  localparam int ADDR_W    = $clog2(ENTRIES),
  localparam int NARROW_AW = $clog2(NARROW_ENTRIES),
  localparam int ZERO_IDX  = ENTRIES - 1,
  localparam int NUM_RD    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               narrow_mode,
  input  logic [ADDR_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0]  rd_a_data,
  input  logic [ADDR_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0]  rd_b_data,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0]  wr_data
);

  rf_view_e          view;
  logic [ADDR_W-1:0] wr_eff_idx;
  logic              commit_en;
  logic [ADDR_W-1:0] commit_idx;
  logic [DATA_W-1:0] commit_data;
  logic [ADDR_W-1:0] rd_idx_arr [NUM_RD];
  logic [ADDR_W-1:0] rd_eff_arr [NUM_RD];
  logic [DATA_W-1:0] rd_raw_arr [NUM_RD];
  logic [DATA_W-1:0] rd_out_arr [NUM_RD];
  logic              bypass_hit [NUM_RD];

  assign view          = rf_view_e'(narrow_mode);
  assign rd_idx_arr[0] = rd_a_idx;
  assign rd_idx_arr[1] = rd_b_idx;
  assign rd_a_data     = rd_out_arr[0];
  assign rd_b_data     = rd_out_arr[1];

  rf_index_map #(.ADDR_W(ADDR_W), .NARROW_AW(NARROW_AW)) u_wr_map (
    .view    (view),
    .idx     (wr_idx),
    .eff_idx (wr_eff_idx)
  );

  rf_write_shaper #(
    .DATA_W(DATA_W), .NARROW_W(NARROW_W), .ADDR_W(ADDR_W), .ZERO_IDX(ZERO_IDX)
  ) u_shaper (
    .view        (view),
    .wr_en       (wr_en),
    .eff_idx     (wr_eff_idx),
    .wr_data     (wr_data),
    .commit_en   (commit_en),
    .commit_idx  (commit_idx),
    .commit_data (commit_data)
  );

  rf_storage #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .NUM_RD(NUM_RD)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit_en   (commit_en),
    .commit_idx  (commit_idx),
    .commit_data (commit_data),
    .rd_idx      (rd_eff_arr),
    .rd_raw      (rd_raw_arr)
  );

  generate
    for (genvar p = 0; p < NUM_RD; p++) begin : g_port
      rf_index_map #(.ADDR_W(ADDR_W), .NARROW_AW(NARROW_AW)) u_map (
        .view    (view),
        .idx     (rd_idx_arr[p]),
        .eff_idx (rd_eff_arr[p])
      );

      rf_read_format #(
        .DATA_W(DATA_W), .NARROW_W(NARROW_W), .ADDR_W(ADDR_W), .ZERO_IDX(ZERO_IDX)
      ) u_fmt (
        .view        (view),
        .eff_idx     (rd_eff_arr[p]),
        .raw         (rd_raw_arr[p]),
        .commit_en   (commit_en),
        .commit_idx  (commit_idx),
        .commit_data (commit_data),
        .bypass_hit  (bypass_hit[p]),
        .rd_data     (rd_out_arr[p])
      );
    end
  endgenerate

endmodule

// File: rtl/rf_checker.sv
`timescale 1ns/1ps
module rf_checker #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 64,
  parameter int NARROW_W  = 32,
  parameter int NARROW_AW = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               narrow_mode,
  input logic [ADDR_W-1:0]  rd_a_idx,
  input logic [DATA_W-1:0]  rd_a_data,
  input logic [ADDR_W-1:0]  rd_b_idx,
  input logic [DATA_W-1:0]  rd_b_data,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_idx,
  input logic [DATA_W-1:0]  wr_data,
  input logic               commit_en,
  input logic [ADDR_W-1:0]  commit_idx
);

  localparam logic [ADDR_W-1:0] TOP_IDX = '1;

  // R2: wide read of the top index is zero on both ports
  a_r2_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!narrow_mode && (rd_a_idx == TOP_IDX || rd_b_idx == TOP_IDX)) |->
    ((rd_a_idx != TOP_IDX || rd_a_data == '0) && (rd_b_idx != TOP_IDX || rd_b_data == '0)));

  // R3: the storage never commits to the zero entry
  a_r3_no_zero_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |-> commit_idx != TOP_IDX);

  // R4: in narrow mode commits stay inside the narrow window
  a_r4_narrow_window: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow_mode && commit_en) |-> commit_idx < ADDR_W'(1 << NARROW_AW));

  // R5: narrow reads never show upper bits
  a_r5_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_mode |-> (rd_a_data[DATA_W-1:NARROW_W] == '0 && rd_b_data[DATA_W-1:NARROW_W] == '0));

  // R7: same-cycle wide write is visible on port A
  a_r7_wide_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !narrow_mode && wr_idx != TOP_IDX && rd_a_idx == wr_idx) |-> rd_a_data == wr_data);

  // R7: same-cycle narrow write is visible on port B as its low word
  a_r7_narrow_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && narrow_mode && rd_b_idx[NARROW_AW-1:0] == wr_idx[NARROW_AW-1:0]) |->
    rd_b_data == {{(DATA_W-NARROW_W){1'b0}}, wr_data[NARROW_W-1:0]});

  // R1: a wide write is held on the next cycle when nothing overwrites it
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && !narrow_mode && wr_idx != TOP_IDX) && !narrow_mode && !wr_en &&
     rd_a_idx == $past(wr_idx)) |-> rd_a_data == $past(wr_data));

  // R9: a disabled write never reaches the storage
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !commit_en);

endmodule

bind dual_view_regfile rf_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W), .NARROW_AW(NARROW_AW)
) u_rf_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .narrow_mode (narrow_mode),
  .rd_a_idx    (rd_a_idx),
  .rd_a_data   (rd_a_data),
  .rd_b_idx    (rd_b_idx),
  .rd_b_data   (rd_b_data),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .wr_data     (wr_data),
  .commit_en   (commit_en),
  .commit_idx  (commit_idx)
);

// File: tb/dual_view_regfile_bench.sv
`timescale 1ns/1ps
module dual_view_regfile_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        narrow_mode = 1'b0;
  logic [5:0]  rd_a_idx = '0;
  logic [5:0]  rd_b_idx = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_a_data;
  logic [63:0] rd_b_data;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // Behavioural model: plain array of integers, one per entry.
  logic [63:0] model [64];

  always #4 clk = ~clk;

  dual_view_regfile u_dual_view_regfile (
    .clk(clk), .rst_n(rst_n), .narrow_mode(narrow_mode),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  function automatic int target(bit m, logic [5:0] i);
    return m ? int'(i % 16) : int'(i);
  endfunction

  function automatic logic [63:0] stored_form(bit m, logic [63:0] d);
    logic [63:0] v;
    if (!m) return d;
    v = {32'h0, d[31:0]};
    if (d[31]) v = v | 64'hFFFF_FFFF_0000_0000;
    return v;
  endfunction

  function automatic logic [63:0] predict(bit m, logic [5:0] ri, bit we,
                                          logic [5:0] wi, logic [63:0] wd);
    int e;
    logic [63:0] v;
    e = target(m, ri);
    if (e == 63) return 64'h0;
    v = model[e];
    if (we && target(m, wi) == e) v = stored_form(m, wd);
    if (m) v = v & 64'h0000_0000_FFFF_FFFF;
    return v;
  endfunction

  task automatic check(string tag, string port, logic [5:0] idx,
                       logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s port %s idx=%0d actual=%h expected=%h", tag, port, idx, got, exp);
    end
  endtask

  task automatic step(string tag, bit m, logic [5:0] ia, logic [5:0] ib,
                      bit we, logic [5:0] wi, logic [63:0] wd);
    int e;
    @(negedge clk);
    narrow_mode = m; rd_a_idx = ia; rd_b_idx = ib;
    wr_en = we; wr_idx = wi; wr_data = wd;
    #2;
    check(tag, "A", ia, rd_a_data, predict(m, ia, we, wi, wd));
    check(tag, "B", ib, rd_b_data, predict(m, ib, we, wi, wd));
    @(posedge clk);
    e = target(m, wi);
    if (we && e != 63) model[e] = stored_form(m, wd);
  endtask

  task automatic sweep(string tag, bit m);
    for (int i = 0; i < 64; i += 2)
      step(tag, m, 6'(i), 6'(i + 1), 1'b0, 6'(i), 64'hDEAD_BEEF_0BAD_F00D);
  endtask

  task automatic do_reset();
    @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b0;
    for (int k = 0; k < 64; k++) model[k] = 64'h0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 64; k++) model[k] = 64'h0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R8: everything reads zero after reset, both views
    sweep("R8", 1'b0);
    sweep("R8", 1'b1);

    // R1: distinct pattern per entry, reads on other entries meanwhile
    for (int i = 0; i < 63; i++)
      step("R1", 1'b0, 6'((i + 7) % 64), 6'((i + 40) % 64), 1'b1, 6'(i),
           (64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h0101_0101_0101_0101)) + 64'(i << 40));
    sweep("R1", 1'b0);

    // R1: walking one and walking zero words on two entries
    for (int b = 0; b < 64; b++) begin
      step("R1", 1'b0, 6'd3, 6'd4, 1'b1, 6'd3, 64'h1 << b);
      step("R1", 1'b0, 6'd3, 6'd4, 1'b1, 6'd4, ~(64'h1 << b));
    end

    // R2 / R3: write to the zero entry, then confirm nothing moved
    step("R3", 1'b0, 6'd63, 6'd62, 1'b1, 6'd63, 64'hFFFF_FFFF_FFFF_FFFF);
    step("R2", 1'b0, 6'd63, 6'd63, 1'b0, 6'd0, 64'h0);
    sweep("R3", 1'b0);

    // R9: disabled writes with live index and data
    for (int i = 0; i < 16; i++)
      step("R9", 1'b0, 6'(i), 6'(i + 16), 1'b0, 6'(i), 64'hCAFE_CAFE_CAFE_CAFE);
    sweep("R9", 1'b0);

    // R6: narrow writes, negative and positive low words, garbage above
    for (int i = 0; i < 16; i++)
      step("R6", 1'b1, 6'(i + 16), 6'(i + 32), 1'b1, 6'(i),
           {32'h5A5A_A5A5 ^ 32'(i), (i % 2 == 0) ? 32'h8000_0001 + 32'(i) : 32'h1234_0000 + 32'(i)});
    sweep("R6", 1'b0);

    // R4: narrow access with high index bits set
    step("R4", 1'b1, 6'd53, 6'd21, 1'b1, 6'd37, 64'hFFFF_0000_F000_0005);
    step("R4", 1'b1, 6'd5, 6'd58, 1'b0, 6'd0, 64'h0);
    step("R4", 1'b1, 6'd47, 6'd31, 1'b1, 6'd63, 64'h0000_0000_7FFF_FFFF);
    step("R4", 1'b0, 6'd5, 6'd15, 1'b0, 6'd0, 64'h0);

    // R5: narrow view of entries that hold wide values
    step("R5", 1'b0, 6'd0, 6'd1, 1'b1, 6'd9, 64'hF0F0_F0F0_8765_4321);
    sweep("R5", 1'b1);

    // R7: same-cycle collisions in both views
    step("R7", 1'b0, 6'd10, 6'd10, 1'b1, 6'd10, 64'hAAAA_5555_AAAA_5555);
    step("R7", 1'b0, 6'd11, 6'd20, 1'b1, 6'd20, 64'h1357_9BDF_2468_ACE0);
    step("R7", 1'b1, 6'd28, 6'd44, 1'b1, 6'd12, 64'h0000_0000_C000_0000);
    step("R7", 1'b1, 6'd2, 6'd18, 1'b1, 6'd50, 64'hFFFF_FFFF_0000_7777);
    step("R7", 1'b0, 6'd12, 6'd2, 1'b0, 6'd0, 64'h0);

    // R8: reset in the middle of the run clears all entries
    do_reset();
    sweep("R8", 1'b0);
    sweep("R8", 1'b1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule